// File: doc/BRIEF.md
# Selectable Card Clock Generator

This block derives the clock for a contact card from a reference clock. In asynchronous mode a two-bit code picks one of four rates: the reference divided by 2, 4 or 8, or the reference itself. Every divided rate is built from equal high and low halves, so the duty cycle is exactly 50%. At the divide-by-one rate the reference waveform goes straight through, so its duty cycle is whatever the reference has.

In synchronous mode the host drives the card clock directly through a strobe input, and the divider output is not used. A clock enable from the activation sequencer gates the card clock. A separate output always carries a copy of the reference clock so that other readers can share it.

The divider is a small state machine with four states:
- `S_OFF`: disabled or in reset; the output is low.
- `S_LOW`: low half of a divided period.
- `S_HIGH`: high half of a divided period.
- `S_PASS`: reference passthrough for divide-by-one.

Its transitions are:
- `OFF→LOW` or `OFF→PASS` when enabled, chosen by the code.
- `LOW→HIGH` at the end of the low half.
- `LOW→PASS` at the end of the low half when the new code is divide-by-one.
- `HIGH→LOW` at the end of the high half.
- `PASS→LOW` when the code leaves divide-by-one.
- Any state goes to `OFF` when the enable drops.

Top module: `card_clk_gen`

## Requirements
- R1: The code `div_sel` maps as 2'b00 = divide by 8, 2'b01 = divide by 1, 2'b10 = divide by 4, 2'b11 = divide by 2.
- R2: With code 2'b01 in asynchronous mode, `card_clk` equals `ref_clk`, both during the high phase and during the low phase.
- R3: With codes 2'b00, 2'b10 and 2'b11, `card_clk` is high for exactly N/2 reference cycles and low for exactly N/2 reference cycles, where N is the divide ratio.
- R4: When `sync_mode` is 0, `card_clk` comes from the divider.
- R5: When `sync_mode` is 1 and `clk_en` is 1, `card_clk` equals `strobe` within the same cycle.
- R6: In asynchronous mode the value of `strobe` has no effect on `card_clk`.
- R7: `ref_clk_out` equals `ref_clk` at every divide setting.
- R8: A new code is adopted only at the end of a low half. The high half in progress and the following low half both finish at the old rate.
- R9: While `clk_en` is 0, `card_clk` is low in both modes. After `clk_en` rises, a divided clock starts with a full low half.
- R10: While `rst_n` is 0, `card_clk` is low. After release, a divided clock starts with a full low half counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Card clock enable from the sequencer |
| div_sel | input | 2 | Divide code |
| sync_mode | input | 1 | 1 = strobe drives the card clock, 0 = divider |
| strobe | input | 1 | Host strobe used in synchronous mode |
| card_clk | output | 1 | Card clock |
| ref_clk_out | output | 1 | Copy of the reference clock |

## Verification
The divided output is taken from the state register, so a new enable, reset release or code becomes visible at the first rising edge after it is applied. The bench therefore drives inputs and samples on falling edges and measures whole high and low runs instead of single cycles. A code change becomes visible only after the current high half and the next low half have run out, which the bench checks as two run lengths at the old rate followed by two at the new rate. The passthrough, strobe and enable paths are combinational, so they are sampled 2 ns after an edge, in the same cycle as the stimulus.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_PASS = 2'd3
    } cclk_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_DIV8 = 2'b00;
    localparam logic [SEL_W-1:0] SEL_DIV1 = 2'b01;
    localparam logic [SEL_W-1:0] SEL_DIV4 = 2'b10;
    localparam logic [SEL_W-1:0] SEL_DIV2 = 2'b11;

    // last count index of one half period (half length minus one)
    function automatic logic [1:0] half_last(input logic [SEL_W-1:0] sel);
        logic [1:0] r;
        unique case (sel)
            SEL_DIV8: r = 2'd3;
            SEL_DIV4: r = 2'd1;
            SEL_DIV2: r = 2'd0;
            SEL_DIV1: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cclk_divider.sv
module cclk_divider
    import cclk_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             div_q,
    output logic             pass_q
);

    cclk_state_e      state, next_state;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [SEL_W-1:0] code_q, code_n;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(half_last(code_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_OFF;
            cnt    <= '0;
            code_q <= SEL_DIV8;
        end else begin
            state  <= next_state;
            cnt    <= cnt_n;
            code_q <= code_n;
        end
    end

    // next-state logic
    always_comb begin
        next_state = state;
        cnt_n      = cnt;
        code_n     = code_q;
        if (!clk_en) begin
            next_state = S_OFF;
            cnt_n      = '0;
        end else begin
            unique case (state)
                S_OFF: begin
                    code_n     = div_sel;
                    cnt_n      = '0;
                    next_state = (div_sel == SEL_DIV1) ? S_PASS : S_LOW;
                end
                S_LOW: begin
                    if (cnt == last) begin
                        cnt_n      = '0;
                        code_n     = div_sel;
                        next_state = (div_sel == SEL_DIV1) ? S_PASS : S_HIGH;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                S_HIGH: begin
                    if (cnt == last) begin
                        cnt_n      = '0;
                        next_state = S_LOW;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                S_PASS: begin
                    if (div_sel != SEL_DIV1) begin
                        code_n     = div_sel;
                        cnt_n      = '0;
                        next_state = S_LOW;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        div_q  = (state == S_HIGH);
        pass_q = (state == S_PASS);
    end

    // R3: the half counter never runs past the half length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R3: a high half can only begin at the end of a low half
    a_r3_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> $past(state) == S_LOW);

    // R8: the code is never replaced while the output is high
    a_r8_code_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HIGH |=> $stable(code_q));

    // R9: dropping the enable parks the divider
    a_r9_en_off: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> state == S_OFF);

endmodule

// File: rtl/cclk_out_mux.sv
module cclk_out_mux (
    input  logic ref_clk,
    input  logic clk_en,
    input  logic sync_mode,
    input  logic strobe,
    input  logic div_q,
    input  logic pass_q,
    output logic card_clk,
    output logic ref_clk_out
);

    logic async_clk;

    always_comb begin
        async_clk   = pass_q ? ref_clk : div_q;
        card_clk    = clk_en & (sync_mode ? strobe : async_clk);
        ref_clk_out = ref_clk;
    end

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import cclk_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             sync_mode,
    input  logic             strobe,
    output logic             card_clk,
    output logic             ref_clk_out
);

    logic div_q;
    logic pass_q;

    cclk_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .div_sel (div_sel),
        .div_q   (div_q),
        .pass_q  (pass_q)
    );

    cclk_out_mux u_mux (
        .ref_clk     (ref_clk),
        .clk_en      (clk_en),
        .sync_mode   (sync_mode),
        .strobe      (strobe),
        .div_q       (div_q),
        .pass_q      (pass_q),
        .card_clk    (card_clk),
        .ref_clk_out (ref_clk_out)
    );

    // R9: no card clock while the sequencer withholds the enable
    a_r9_hold_low: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !clk_en |-> !card_clk);

endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;

    logic       ref_clk = 1'b0;
    logic       rst_n;
    logic       clk_en;
    logic [1:0] div_sel;
    logic       sync_mode;
    logic       strobe;
    logic       card_clk;
    logic       ref_clk_out;

    int tests = 0;
    int fails = 0;

    always #4 ref_clk = ~ref_clk;   // 125 MHz

    card_clk_gen uut (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .div_sel     (div_sel),
        .sync_mode   (sync_mode),
        .strobe      (strobe),
        .card_clk    (card_clk),
        .ref_clk_out (ref_clk_out)
    );

    // {div_sel, strobe, expected half length; 0 = passthrough}
    localparam logic [5:0] VEC [8] = '{
        {2'b00, 1'b0, 3'd4},
        {2'b10, 1'b1, 3'd2},
        {2'b11, 1'b0, 3'd1},
        {2'b01, 1'b0, 3'd0},
        {2'b00, 1'b1, 3'd4},
        {2'b11, 1'b1, 3'd1},
        {2'b10, 1'b0, 3'd2},
        {2'b01, 1'b1, 3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count a run of `lvl` that has already produced one sample
    task automatic count_run(input logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge ref_clk);
            if (card_clk !== lvl) break;
            n++;
        end
    endtask

    task automatic runs(input bit do_chg, input logic [1:0] nsel,
                        output int h1, output int l1, output int h2, output int l2);
        logic p;
        @(negedge ref_clk);
        p = card_clk;
        for (int i = 0; i < 40; i++) begin
            @(negedge ref_clk);
            if (!p && card_clk) break;
            p = card_clk;
        end
        if (do_chg) div_sel = nsel;
        count_run(1'b1, h1);
        count_run(1'b0, l1);
        count_run(1'b1, h2);
        count_run(1'b0, l2);
    endtask

    task automatic check_pass(input string req);
        @(posedge ref_clk); #2;
        check(card_clk === 1'b1, req, card_clk, 1);
        check(ref_clk_out === 1'b1, "R7 copy high", ref_clk_out, 1);
        @(negedge ref_clk); #2;
        check(card_clk === 1'b0, req, card_clk, 0);
        check(ref_clk_out === 1'b0, "R7 copy low", ref_clk_out, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge ref_clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int h1, l1, h2, l2, lows;
        rst_n = 1'b0; clk_en = 1'b0; div_sel = 2'b00; sync_mode = 1'b0; strobe = 1'b0;
        repeat (3) @(negedge ref_clk);
        check(card_clk === 1'b0, "R10 reset low", card_clk, 0);
        clk_en = 1'b1;
        repeat (3) @(negedge ref_clk);
        check(card_clk === 1'b0, "R10 reset low with enable", card_clk, 0);
        rst_n = 1'b1;

        // vector table: R1 R3 R4 R6 R2 R7
        for (int v = 0; v < 8; v++) begin
            div_sel = VEC[v][5:4];
            strobe  = VEC[v][3];
            repeat (20) @(negedge ref_clk);
            if (VEC[v][2:0] == 3'd0) begin
                check_pass("R2 R1 divide-by-one passthrough");
            end else begin
                runs(1'b0, 2'b00, h1, l1, h2, l2);
                check(h1 == int'(VEC[v][2:0]), "R1 R3 R4 high half", h1, VEC[v][2:0]);
                check(l1 == int'(VEC[v][2:0]), "R3 R6 low half", l1, VEC[v][2:0]);
                @(posedge ref_clk); #2;
                check(ref_clk_out === 1'b1, "R7 copy while dividing", ref_clk_out, 1);
            end
        end
        strobe = 1'b0;

        // R8: code change mid high, slow to fast
        div_sel = 2'b00;
        repeat (20) @(negedge ref_clk);
        runs(1'b1, 2'b11, h1, l1, h2, l2);
        check(h1 == 4, "R8 old high finishes", h1, 4);
        check(l1 == 4, "R8 old low finishes", l1, 4);
        check(h2 == 1, "R8 new high", h2, 1);
        check(l2 == 1, "R8 new low", l2, 1);
        // R8: fast to slow
        runs(1'b1, 2'b00, h1, l1, h2, l2);
        check(h1 == 1 && l1 == 1, "R8 old rate kept", h1 * 10 + l1, 11);
        check(h2 == 4 && l2 == 4, "R8 new rate", h2 * 10 + l2, 44);

        // R9: enable low holds output low
        @(negedge ref_clk);
        clk_en = 1'b0; strobe = 1'b1;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge ref_clk);
            if (card_clk === 1'b0) lows++;
        end
        check(lows == 10, "R9 held low", lows, 10);
        strobe = 1'b0; div_sel = 2'b10; clk_en = 1'b1;
        @(negedge ref_clk);
        check(card_clk === 1'b0, "R9 restart low 1", card_clk, 0);
        @(negedge ref_clk);
        check(card_clk === 1'b0, "R9 restart low 2", card_clk, 0);
        @(negedge ref_clk);
        check(card_clk === 1'b1, "R9 restart first high", card_clk, 1);

        // R5: synchronous mode follows strobe
        sync_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge ref_clk);
            div_sel = 2'(i);
            strobe  = i[0] ^ i[2];
            #2;
            check(card_clk === strobe, "R5 strobe passthrough", card_clk, strobe);
        end
        strobe = 1'b1; clk_en = 1'b0; #2;
        check(card_clk === 1'b0, "R9 sync disabled low", card_clk, 0);
        @(negedge ref_clk);
        clk_en = 1'b1; sync_mode = 1'b0; strobe = 1'b0;

        // R10: reset mid run, counter restarts from zero
        div_sel = 2'b00;
        repeat (20) @(negedge ref_clk);
        rst_n = 1'b0; #1;
        check(card_clk === 1'b0, "R10 reset forces low", card_clk, 0);
        @(negedge ref_clk);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge ref_clk);
            if (card_clk === 1'b1) break;
            lows++;
        end
        check(lows == 4, "R10 first low half after reset", lows, 4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule